// File: doc/BRIEF.md
# Doorbell Mailbox Receive Controller

This block is the receive side of a three-channel doorbell between a remote control processor and a host processor. The remote side drops a 32-bit command word into one channel slot. That write also marks the channel as pending. While any pending channel is both enabled and routed, a level-high interrupt line to the host stays asserted.

To service the interrupt, the host reads the 64-bit pending register and then reads the command word of each pending channel. It acknowledges a channel by writing a one to that channel's bit in the acknowledge register. The host reaches all of this through a small valid/ready register port that carries 32-bit and 64-bit accesses.

The register map is fixed:

| Register | Offset |
|---|---|
| Channel i command slot | 0x100 + 8*i, with the command word at slot + 4 |
| Routing mask | 0x4000 |
| Pending | 0x4400 |
| Acknowledge | 0x4800 |
| Enable | 0x4C00 |

Bit i of each 64-bit register belongs to channel i.

Top module: `dbell_rx_mbox`

## Requirements
- R1: After reset, every command word, the pending, enable and routing bits are zero, and `hostIrq` is low.
- R2: A remote post on channel c (0..2) stores its word and sets pending bit c at the next clock edge. The word can be read back in two ways: a 32-bit read at 0x100+8c+4 returns it in rdata[31:0], and a 64-bit read at 0x100+8c returns it in rdata[63:32] with the lower half zero.
- R3: The pending register at 0x4400 shows the raw pending bits, whatever the enable and routing values are.
- R4: A write to 0x4800 clears each pending bit whose data bit is one. Data bits that are zero leave their pending bits unchanged.
- R5: If an acknowledge and a remote post hit the same channel in the same cycle, the post wins and the pending bit stays set.
- R6: `hostIrq` is high exactly while some channel has its pending, enable and routing bits all set. It stays high until all such channels are acknowledged.
- R7: A channel whose enable bit is zero, or whose routing bit is zero, never raises `hostIrq`.
- R8: Bits 63:3 of the routing, enable, pending and acknowledge registers read as zero and ignore writes.
- R9: Reads of unmapped addresses return zero. Host writes to command slots have no effect.
- R10: The block answers each access with `busReady` high for exactly one cycle, one cycle after `busValid` is first seen. A write takes effect at the edge where valid and ready are both high, and read data is valid while `busReady` is high.
- R11: `busWide`=0 selects a 32-bit access to the word chosen by address bit 2. A 32-bit write to the upper word (bit 2 set) of a control register has no effect, and a 32-bit read of an upper word returns it in rdata[31:0].
- R12: A remote post with channel code 3 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busValid | input | 1 | Host access request, held until busReady |
| busWrite | input | 1 | 1 = write, 0 = read |
| busWide | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| busAddr | input | 16 | Byte address |
| busWdata | input | 64 | Write data (32-bit writes use bits 31:0) |
| busReady | output | 1 | Access completes this cycle |
| busRdata | output | 64 | Read data, valid with busReady |
| remotePostValid | input | 1 | Remote side posts a command word |
| remoteChan | input | 2 | Channel of the post |
| remoteData | input | 32 | Posted command word |
| hostIrq | output | 1 | Level-high interrupt to the host |

## Verification
The assertions check a few rules on every cycle:
- the one-cycle ready pulse and its timing after valid;
- that a post sets its channel's pending bit, even against a simultaneous acknowledge;
- that an acknowledge of channel 0 without a competing post clears that bit;
- that the interrupt never rises without a pending, enabled channel.

Other behaviours are visible only through the bench's scenarios:
- the address decode and the read-back values;
- the 32-bit half selection;
- the ignored upper bits and the ignored slot writes;
- the routing mask gating the interrupt;
- reset clearing state in the middle of a run.

// File: rtl/dbmb_pkg.sv
package dbmb_pkg;

  localparam int BUS_W    = 64;
  localparam int SLOT_W   = 4;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_SLOT,
    SEL_MAP,
    SEL_STAT,
    SEL_CLR,
    SEL_EN
  } regSel_e;

  typedef struct packed {
    logic              wrMap;
    logic              wrEnable;
    logic              wrClear;
    logic              capture;
    regSel_e           sel;
    logic [SLOT_W-1:0] slot;
    logic              hiHalf;
    logic              wide;
  } dbmbStrobe_t;

endpackage

// File: rtl/dbmb_ctrl.sv
module dbmb_ctrl
  import dbmb_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              NUM_CH    = 3,
  parameter logic [15:0]     SLOT_BASE = 16'h0100,
  parameter logic [15:0]     MAP_OFF   = 16'h4000,
  parameter logic [15:0]     STAT_OFF  = 16'h4400,
  parameter logic [15:0]     CLR_OFF   = 16'h4800,
  parameter logic [15:0]     EN_OFF    = 16'h4C00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busWrite,
  input  logic              busWide,
  input  logic [ADDR_W-1:0] busAddr,
  output logic              busReady,
  output dbmbStrobe_t       strb
);

  logic              readyQ;
  logic [ADDR_W-1:0] qwordAddr;
  logic              aligned;
  logic              writable;
  logic              handshake;
  regSel_e           selD;
  logic [SLOT_W-1:0] slotD;

  // one wait state: ready pulses the cycle after valid is first seen
  always_ff @(posedge clk) begin
    if (!rstN) readyQ <= 1'b0;
    else       readyQ <= busValid && !readyQ;
  end

  assign busReady  = readyQ;
  assign qwordAddr = {busAddr[ADDR_W-1:3], 3'b000};
  assign aligned   = (busAddr[1:0] == 2'b00) && !(busWide && busAddr[2]);
  assign writable  = busWide || !busAddr[2];
  assign handshake = busValid && readyQ && busWrite;

  always_comb begin
    selD  = SEL_NONE;
    slotD = '0;
    if (aligned) begin
      if (qwordAddr == MAP_OFF[ADDR_W-1:0])       selD = SEL_MAP;
      else if (qwordAddr == STAT_OFF[ADDR_W-1:0]) selD = SEL_STAT;
      else if (qwordAddr == CLR_OFF[ADDR_W-1:0])  selD = SEL_CLR;
      else if (qwordAddr == EN_OFF[ADDR_W-1:0])   selD = SEL_EN;
      for (int i = 0; i < NUM_CH; i++) begin
        if (qwordAddr == ADDR_W'(32'(SLOT_BASE) + 8 * i)) begin
          selD  = SEL_SLOT;
          slotD = SLOT_W'(i);
        end
      end
    end
  end

  always_comb begin
    strb          = '0;
    strb.sel      = selD;
    strb.slot     = slotD;
    strb.hiHalf   = busAddr[2];
    strb.wide     = busWide;
    strb.capture  = busValid && !readyQ && !busWrite;
    strb.wrMap    = handshake && writable && (selD == SEL_MAP);
    strb.wrEnable = handshake && writable && (selD == SEL_EN);
    strb.wrClear  = handshake && writable && (selD == SEL_CLR);
  end

endmodule

// File: rtl/dbmb_dpath.sv
module dbmb_dpath
  import dbmb_pkg::*;
#(
  parameter int NUM_CH   = 3,
  parameter int CMD_W    = 32,
  parameter int CH_IDX_W = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  dbmbStrobe_t         strb,
  input  logic [NUM_CH-1:0]   wrBits,
  input  logic                remotePostValid,
  input  logic [CH_IDX_W-1:0] remoteChan,
  input  logic [CMD_W-1:0]    remoteData,
  output logic [BUS_W-1:0]    rdata,
  output logic [NUM_CH-1:0]   statusQ,
  output logic [NUM_CH-1:0]   enableQ,
  output logic [NUM_CH-1:0]   mapQ,
  output logic                irq
);

  localparam int PAD_W = BUS_W - NUM_CH;
  localparam int HALF  = BUS_W / 2;

  logic [CMD_W-1:0] cmdQ [NUM_CH];
  logic [BUS_W-1:0] fullWord;
  logic [BUS_W-1:0] readWord;
  logic [BUS_W-1:0] rdataQ;
  logic [CMD_W-1:0] slotWord;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    logic postHit;
    assign postHit = remotePostValid && (remoteChan == CH_IDX_W'(g));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cmdQ[g]    <= '0;
        statusQ[g] <= 1'b0;
      end else if (postHit) begin
        cmdQ[g]    <= remoteData;
        statusQ[g] <= 1'b1;
      end else if (strb.wrClear && wrBits[g]) begin
        statusQ[g] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enableQ <= '0;
      mapQ    <= '0;
    end else begin
      if (strb.wrEnable) enableQ <= wrBits;
      if (strb.wrMap)    mapQ    <= wrBits;
    end
  end

  assign irq = |(statusQ & enableQ & mapQ);

  always_comb begin
    slotWord = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (strb.slot == SLOT_W'(i)) slotWord = cmdQ[i];
    end
  end

  always_comb begin
    case (strb.sel)
      SEL_SLOT: fullWord = {slotWord, {(BUS_W - CMD_W){1'b0}}};
      SEL_MAP:  fullWord = {{PAD_W{1'b0}}, mapQ};
      SEL_STAT: fullWord = {{PAD_W{1'b0}}, statusQ};
      SEL_EN:   fullWord = {{PAD_W{1'b0}}, enableQ};
      default:  fullWord = '0;
    endcase
    if (strb.wide)        readWord = fullWord;
    else if (strb.hiHalf) readWord = {{HALF{1'b0}}, fullWord[BUS_W-1:HALF]};
    else                  readWord = {{HALF{1'b0}}, fullWord[HALF-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdataQ <= '0;
    else if (strb.capture) rdataQ <= readWord;
  end

  assign rdata = rdataQ;

endmodule

// File: rtl/dbell_rx_mbox.sv
module dbell_rx_mbox
  import dbmb_pkg::*;
#(
  parameter int          NUM_CH    = 3,
  parameter int          ADDR_W    = 16,
  parameter int          CMD_W     = 32,
  parameter logic [15:0] SLOT_BASE = 16'h0100,
  parameter logic [15:0] MAP_OFF   = 16'h4000,
  parameter logic [15:0] STAT_OFF  = 16'h4400,
  parameter logic [15:0] CLR_OFF   = 16'h4800,
  parameter logic [15:0] EN_OFF    = 16'h4C00,
  localparam int         CH_IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH + 1) : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busValid,
  input  logic                busWrite,
  input  logic                busWide,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [BUS_W-1:0]    busWdata,
  output logic                busReady,
  output logic [BUS_W-1:0]    busRdata,
  input  logic                remotePostValid,
  input  logic [CH_IDX_W-1:0] remoteChan,
  input  logic [CMD_W-1:0]    remoteData,
  output logic                hostIrq
);

  dbmbStrobe_t       strb;
  logic [NUM_CH-1:0] statusQ;
  logic [NUM_CH-1:0] enableQ;
  logic [NUM_CH-1:0] mapQ;

  dbmb_ctrl #(
    .ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .SLOT_BASE(SLOT_BASE),
    .MAP_OFF(MAP_OFF), .STAT_OFF(STAT_OFF), .CLR_OFF(CLR_OFF), .EN_OFF(EN_OFF)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWide(busWide), .busAddr(busAddr), .busReady(busReady), .strb(strb)
  );

  dbmb_dpath #(
    .NUM_CH(NUM_CH), .CMD_W(CMD_W), .CH_IDX_W(CH_IDX_W)
  ) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .wrBits(busWdata[NUM_CH-1:0]),
    .remotePostValid(remotePostValid), .remoteChan(remoteChan),
    .remoteData(remoteData), .rdata(busRdata), .statusQ(statusQ),
    .enableQ(enableQ), .mapQ(mapQ), .irq(hostIrq)
  );

endmodule

// File: rtl/dbmb_checker.sv
module dbmb_checker #(
  parameter int          NUM_CH   = 3,
  parameter int          ADDR_W   = 16,
  parameter int          CH_IDX_W = 2,
  parameter logic [15:0] CLR_OFF  = 16'h4800
) (
  input logic                clk,
  input logic                rstN,
  input logic                busValid,
  input logic                busWrite,
  input logic                busWide,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [63:0]         busWdata,
  input logic                busReady,
  input logic                remotePostValid,
  input logic [CH_IDX_W-1:0] remoteChan,
  input logic                hostIrq,
  input logic [NUM_CH-1:0]   statusQ,
  input logic [NUM_CH-1:0]   enableQ
);

  // R10: ready is a single-cycle pulse
  a_r10_ready_pulse: assert property (@(posedge clk) disable iff (!rstN)
    busReady |=> !busReady);

  // R10: ready follows a fresh request by one cycle
  a_r10_ready_follows: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && !busReady) |=> busReady);

  // R6: no interrupt without a pending, enabled channel
  a_r6_irq_needs_source: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |-> |(statusQ & enableQ));

  // R4: acknowledging channel 0 with no competing post clears it
  a_r4_clear_ch0: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busReady && busWrite && busWide && busAddr == CLR_OFF[ADDR_W-1:0]
     && busWdata[0] && !(remotePostValid && remoteChan == '0)) |=> !statusQ[0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_post
    // R2 and R5: a post always leaves its pending bit set
    a_r2_post_sets: assert property (@(posedge clk) disable iff (!rstN)
      (remotePostValid && remoteChan == CH_IDX_W'(g)) |=> statusQ[g]);
  end

endmodule

bind dbell_rx_mbox dbmb_checker #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CH_IDX_W(CH_IDX_W), .CLR_OFF(CLR_OFF)
) chk_i (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
  .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
  .busReady(busReady), .remotePostValid(remotePostValid),
  .remoteChan(remoteChan), .hostIrq(hostIrq), .statusQ(statusQ),
  .enableQ(enableQ)
);

// File: tb/dbell_rx_mbox_tb_top.sv
`timescale 1ns/1ps
module dbell_rx_mbox_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busValid = 1'b0, busWrite = 1'b0, busWide = 1'b0;
  logic [15:0] busAddr = '0;
  logic [63:0] busWdata = '0;
  logic        busReady;
  logic [63:0] busRdata;
  logic        remotePostValid = 1'b0;
  logic [1:0]  remoteChan = '0;
  logic [31:0] remoteData = '0;
  logic        hostIrq;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  dbell_rx_mbox dut_i (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busWrite(busWrite),
    .busWide(busWide), .busAddr(busAddr), .busWdata(busWdata),
    .busReady(busReady), .busRdata(busRdata),
    .remotePostValid(remotePostValid), .remoteChan(remoteChan),
    .remoteData(remoteData), .hostIrq(hostIrq)
  );

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic post(logic [1:0] ch, logic [31:0] d);
    @(negedge clk);
    remotePostValid = 1'b1; remoteChan = ch; remoteData = d;
    @(negedge clk);
    remotePostValid = 1'b0;
  endtask

  task automatic access(logic wr, logic wide, logic [15:0] a, logic [63:0] d,
                        output logic [63:0] rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = wr; busWide = wide; busAddr = a; busWdata = d;
    @(negedge clk);
    check("R10 ready", 64'(busReady), 64'd1);
    rd = busRdata;
    @(negedge clk);
    busValid = 1'b0;
    check("R10 pulse", 64'(busReady), 64'd0);
  endtask

  // op: 0 post (addr = channel), 1 write, 2 read and compare
  localparam int VW = 2 + 1 + 16 + 64 + 64 + 1;
  localparam int NV = 26;
  localparam logic [VW-1:0] VEC [NV] = '{
    {2'd2, 1'b1, 16'h4400, 64'h0, 64'h0, 1'b0},                                   // R1
    {2'd1, 1'b1, 16'h4000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 1'b0},                 // R7
    {2'd2, 1'b1, 16'h4000, 64'h0, 64'h7, 1'b0},                                   // R8
    {2'd0, 1'b1, 16'h0001, 64'hA5A5_0001, 64'h0, 1'b0},                           // R7 not enabled
    {2'd2, 1'b1, 16'h4400, 64'h0, 64'h2, 1'b0},                                   // R3
    {2'd2, 1'b0, 16'h010C, 64'h0, 64'hA5A5_0001, 1'b0},                           // R2
    {2'd2, 1'b1, 16'h0108, 64'h0, 64'hA5A5_0001_0000_0000, 1'b0},                 // R2
    {2'd1, 1'b1, 16'h4C00, 64'hFFFF_FFFF_FFFF_FFFA, 64'h0, 1'b1},                 // R6
    {2'd2, 1'b1, 16'h4C00, 64'h0, 64'h2, 1'b1},                                   // R8
    {2'd1, 1'b1, 16'h4800, 64'h0, 64'h0, 1'b1},                                   // R4 zeros
    {2'd2, 1'b1, 16'h4400, 64'h0, 64'h2, 1'b1},                                   // R4
    {2'd0, 1'b1, 16'h0000, 64'h11, 64'h0, 1'b1},                                  // R6
    {2'd1, 1'b1, 16'h4800, 64'h2, 64'h0, 1'b0},                                   // R4 R6
    {2'd2, 1'b1, 16'h4400, 64'h0, 64'h1, 1'b0},                                   // R4
    {2'd1, 1'b0, 16'h4C04, 64'h1, 64'h0, 1'b0},                                   // R11
    {2'd2, 1'b1, 16'h4C00, 64'h0, 64'h2, 1'b0},                                   // R11
    {2'd1, 1'b0, 16'h4C00, 64'h1, 64'h0, 1'b1},                                   // R11
    {2'd1, 1'b1, 16'h4000, 64'h0, 64'h0, 1'b0},                                   // R7 map
    {2'd2, 1'b1, 16'h4000, 64'h0, 64'h0, 1'b0},                                   // R7
    {2'd2, 1'b1, 16'h2000, 64'h0, 64'h0, 1'b0},                                   // R9
    {2'd1, 1'b1, 16'h0100, 64'hDEAD_BEEF_DEAD_BEEF, 64'h0, 1'b0},                 // R9
    {2'd2, 1'b0, 16'h0104, 64'h0, 64'h11, 1'b0},                                  // R9
    {2'd0, 1'b1, 16'h0003, 64'h77, 64'h0, 1'b0},                                  // R12
    {2'd2, 1'b1, 16'h4400, 64'h0, 64'h1, 1'b0},                                   // R12
    {2'd1, 1'b1, 16'h4800, 64'h1, 64'h0, 1'b0},                                   // R4
    {2'd2, 1'b0, 16'h4404, 64'h0, 64'h0, 1'b0}                                    // R11 upper
  };

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<=20000", cycles);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin : main
    logic [63:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 irq", 64'(hostIrq), 64'd0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic        wide;
      logic [15:0] a;
      logic [63:0] d, exp;
      logic        expIrq;
      {op, wide, a, d, exp, expIrq} = VEC[i];
      if (op == 2'd0) post(a[1:0], d[31:0]);
      else begin
        access(op == 2'd1, wide, a, d, rd);
        if (op == 2'd2) check($sformatf("R2/R3/R8/R9/R11 vec%0d", i), rd, exp);
      end
      check($sformatf("R6/R7 irq vec%0d", i), 64'(hostIrq), 64'(expIrq));
    end

    // R5: post and acknowledge on channel 2 in the same cycle
    access(1'b1, 1'b1, 16'h4000, 64'h7, rd);
    access(1'b1, 1'b1, 16'h4C00, 64'h4, rd);
    @(negedge clk);
    busValid = 1'b1; busWrite = 1'b1; busWide = 1'b1; busAddr = 16'h4800; busWdata = 64'h4;
    @(negedge clk);
    remotePostValid = 1'b1; remoteChan = 2'd2; remoteData = 32'h55;
    @(negedge clk);
    busValid = 1'b0; remotePostValid = 1'b0;
    check("R5 irq", 64'(hostIrq), 64'd1);
    access(1'b0, 1'b1, 16'h4400, 64'h0, rd);
    check("R5 status", rd, 64'h4);
    access(1'b1, 1'b1, 16'h4800, 64'h4, rd);
    check("R4 irq released", 64'(hostIrq), 64'd0);

    // R1: reset in the middle of a run
    post(2'd2, 32'h99);
    check("R6 irq before reset", 64'(hostIrq), 64'd1);
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    check("R1 irq after reset", 64'(hostIrq), 64'd0);
    access(1'b0, 1'b1, 16'h4400, 64'h0, rd); check("R1 status", rd, 64'h0);
    access(1'b0, 1'b1, 16'h4C00, 64'h0, rd); check("R1 enable", rd, 64'h0);
    access(1'b0, 1'b1, 16'h4000, 64'h0, rd); check("R1 map", rd, 64'h0);
    access(1'b0, 1'b0, 16'h0114, 64'h0, rd); check("R1 cmd", rd, 64'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule